// File: doc/BRIEF.md
# Fetch-Side Translation Fence Sequencer

This block lives in the control path of an in-order pipeline and carries out an address-targeted translation fence on the instruction side. The instruction TLB is always looked up with the fetch program counter, so no second address path is added in front of it. Instead, when a fence reaches the memory stage, fetch is steered to the fence's address operand. The TLB's lookup port therefore sees that address. In the next cycle the fence, now in writeback, raises a strobe to the instruction side and is replayed from its own PC.

A sticky done flag remembers that the flush has happened. When the replayed fence is decoded again, its memory operation is cancelled. It then flows through as a pipeline flush that resumes fetch at the fence PC plus 4. A fence whose address operand is the zero register asks for a full flush: it skips the operand redirect and only replays.

The same memory-stage target path also serves indirect jumps. This is why the misaligned-target flag exists, and why it is masked for fences. The block follows its own fence through the execute, memory and writeback stages, advancing one stage per cycle.

Top module: `fetch_fence_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `redirect_valid`, `replay`, `itlb_fence` and `redirect_misaligned` are all 0.
- R2: A fence decoded with `id_has_addr`=1 and the done flag clear reaches the memory stage two cycles after decode. In that cycle `replay`=1, `redirect_valid`=1, and `redirect_target` equals `id_operand` with bit 0 cleared.
- R3: `redirect_misaligned` is 1 only for an indirect-jump redirect whose target has bit 1 set while `HALFWORD_OK`=0. It is always 0 for every fence-caused redirect.
- R4: A fence decoded with `id_has_addr`=0 and the done flag clear raises `replay`=1 in the memory stage with `redirect_valid`=0.
- R5: The cycle after the memory-stage replay, `itlb_fence` pulses for exactly one cycle. In that cycle `itlb_fence_by_addr` equals the fence's `id_has_addr`, and `redirect_valid`=1 with `redirect_target` equal to the fence PC.
- R6: The `itlb_fence` pulse sets the done flag. A fence decoded while the flag is set gives no replay and no `itlb_fence`. In its memory-stage cycle it gives `redirect_valid`=1 with target equal to its PC plus 4.
- R7: The done flag is cleared by a one-cycle `wb_retire` pulse, by a `wb_xcpt` pulse, or by a done-flag fence retiring. The next fence decoded after the clear runs the full replay sequence again.
- R8: `wb_xcpt` high squashes everything younger than writeback. With a fence in the memory stage, `replay` and `redirect_valid` are 0 in that cycle and no `itlb_fence` follows. With a fence in writeback, `itlb_fence` and `redirect_valid` are 0.
- R9: `mem_jump`=1, with no fence in the memory or writeback stage, gives `redirect_valid`=1, `redirect_target` = `mem_jump_addr` with bit 0 cleared, and `replay`=0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_fence | input | 1 | A valid fence is decoded this cycle |
| id_has_addr | input | 1 | Fence address operand register is nonzero |
| id_pc | input | AW | PC of the decoded fence |
| id_operand | input | AW | Address operand value of the fence |
| mem_jump | input | 1 | Valid indirect jump in the memory stage |
| mem_jump_addr | input | AW | Computed indirect-jump address |
| wb_retire | input | 1 | Another instruction validly retires in writeback |
| wb_xcpt | input | 1 | Exception taken in writeback |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_target | output | AW | Fetch redirect address |
| redirect_misaligned | output | 1 | Redirect target is not instruction-aligned |
| replay | output | 1 | Memory-stage replay request for the fence |
| itlb_fence | output | 1 | Fence strobe to the instruction TLB side |
| itlb_fence_by_addr | output | 1 | Strobe targets one address rather than all entries |

## Verification
The assertions assume that every fence PC the environment supplies is even. They also assume that no indirect jump is in the memory stage while a fence occupies the memory or writeback stage. The bench presents fences with word-aligned PCs only. It separates each fence sequence from the next with idle cycles, so that the done flag has settled before the next decode. It raises `mem_jump` only while the pipeline holds no fence. Exceptions are injected only at the memory-stage and writeback-stage cycles of a fence, or while the pipeline is idle.

// File: rtl/fetch_fence_pkg.sv
package fetch_fence_pkg;

  typedef struct packed {
    logic valid;
    logic memop;
    logic has_addr;
  } stage_ctl_t;

  typedef enum logic [1:0] {
    SRC_NONE      = 2'd0,
    SRC_WB_REPLAY = 2'd1,
    SRC_MEM_FENCE = 2'd2,
    SRC_MEM_JUMP  = 2'd3
  } redirect_src_e;

endpackage

// File: rtl/fence_stage_pipe.sv
module fence_stage_pipe
  import fetch_fence_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_fence,
  input  logic          id_has_addr,
  input  logic [AW-1:0] id_pc,
  input  logic [AW-1:0] id_operand,
  input  logic          done,
  input  logic          kill_wb,
  input  logic          kill_mem,
  output stage_ctl_t    mem_ctl,
  output logic [AW-1:0] mem_pc,
  output logic [AW-1:0] mem_op,
  output stage_ctl_t    wb_ctl,
  output logic [AW-1:0] wb_pc
);
  localparam int NST = 3;
  localparam int MEM_IDX = 1;
  localparam int WB_IDX = 2;

  stage_ctl_t    ctl_q [NST];
  logic [AW-1:0] pc_q  [NST];
  logic [AW-1:0] op_q  [NST];

  stage_ctl_t id_ctl;
  always_comb begin
    id_ctl.valid    = id_fence;
    id_ctl.memop    = !done;
    id_ctl.has_addr = id_has_addr;
  end

  for (genvar i = 0; i < NST; i++) begin : g_stage
    stage_ctl_t    ctl_in;
    logic [AW-1:0] pc_in;
    logic [AW-1:0] op_in;
    logic          squash;

    if (i == 0) begin : g_head
      assign ctl_in = id_ctl;
      assign pc_in  = id_pc;
      assign op_in  = id_operand;
    end else begin : g_body
      assign ctl_in = ctl_q[i-1];
      assign pc_in  = pc_q[i-1];
      assign op_in  = op_q[i-1];
    end

    if (i <= MEM_IDX) begin : g_young
      assign squash = kill_wb || kill_mem;
    end else begin : g_old
      assign squash = kill_wb;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[i] <= '0;
        pc_q[i]  <= '0;
        op_q[i]  <= '0;
      end else begin
        ctl_q[i].valid    <= ctl_in.valid && !squash;
        ctl_q[i].memop    <= ctl_in.memop;
        ctl_q[i].has_addr <= ctl_in.has_addr;
        pc_q[i]           <= pc_in;
        op_q[i]           <= op_in;
      end
    end
  end

  assign mem_ctl = ctl_q[MEM_IDX];
  assign mem_pc  = pc_q[MEM_IDX];
  assign mem_op  = op_q[MEM_IDX];
  assign wb_ctl  = ctl_q[WB_IDX];
  assign wb_pc   = pc_q[WB_IDX];
endmodule

// File: rtl/fence_done_flag.sv
module fence_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clear,
  output logic done
);
  always_ff @(posedge clk) begin
    if (rst)        done <= 1'b0;
    else if (set)   done <= 1'b1;
    else if (clear) done <= 1'b0;
  end
endmodule

// File: rtl/fence_redirect_sel.sv
module fence_redirect_sel
  import fetch_fence_pkg::*;
#(
  parameter int AW          = 32,
  parameter bit HALFWORD_OK = 1'b0,
  parameter int INSN_BYTES  = 4
) (
  input  stage_ctl_t    mem_ctl,
  input  logic [AW-1:0] mem_pc,
  input  logic [AW-1:0] mem_op,
  input  stage_ctl_t    wb_ctl,
  input  logic [AW-1:0] wb_pc,
  input  logic          wb_xcpt,
  input  logic          mem_jump,
  input  logic [AW-1:0] mem_jump_addr,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_target,
  output logic          redirect_misaligned,
  output logic          replay,
  output logic          strobe,
  output logic          strobe_by_addr,
  output logic          kill_wb,
  output logic          kill_mem
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);
  localparam logic [AW-1:0] LSB_CLEAR = ~AW'(1);

  redirect_src_e src;
  logic          wb_replay;
  logic          mem_live;
  logic [AW-1:0] indirect_addr;
  logic          mem_fence_redir;

  always_comb begin
    wb_replay       = wb_ctl.valid && wb_ctl.memop && !wb_xcpt;
    kill_wb         = wb_replay || wb_xcpt;
    mem_live        = mem_ctl.valid && !kill_wb;
    replay          = mem_live && mem_ctl.memop;
    mem_fence_redir = mem_live && (!mem_ctl.memop || mem_ctl.has_addr);
    indirect_addr   = (mem_ctl.valid ? mem_op : mem_jump_addr) & LSB_CLEAR;

    if (wb_replay)                               src = SRC_WB_REPLAY;
    else if (mem_fence_redir)                    src = SRC_MEM_FENCE;
    else if (mem_jump && !kill_wb && !mem_ctl.valid) src = SRC_MEM_JUMP;
    else                                         src = SRC_NONE;

    redirect_valid      = (src != SRC_NONE);
    redirect_misaligned = 1'b0;
    unique case (src)
      SRC_WB_REPLAY: redirect_target = wb_pc;
      SRC_MEM_FENCE: redirect_target = mem_ctl.memop ? indirect_addr : mem_pc + STEP;
      SRC_MEM_JUMP: begin
        redirect_target     = indirect_addr;
        redirect_misaligned = !HALFWORD_OK && indirect_addr[1];
      end
      default:       redirect_target = '0;
    endcase

    kill_mem       = replay || redirect_valid;
    strobe         = wb_replay;
    strobe_by_addr = wb_replay && wb_ctl.has_addr;
  end
endmodule

// File: rtl/fetch_fence_seq.sv
module fetch_fence_seq
  import fetch_fence_pkg::*;
#(
  parameter int AW          = 32,
  parameter bit HALFWORD_OK = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          id_fence,
  input  logic          id_has_addr,
  input  logic [AW-1:0] id_pc,
  input  logic [AW-1:0] id_operand,
  input  logic          mem_jump,
  input  logic [AW-1:0] mem_jump_addr,
  input  logic          wb_retire,
  input  logic          wb_xcpt,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_target,
  output logic          redirect_misaligned,
  output logic          replay,
  output logic          itlb_fence,
  output logic          itlb_fence_by_addr
);
  stage_ctl_t    mem_ctl, wb_ctl;
  logic [AW-1:0] mem_pc, mem_op, wb_pc;
  logic          done, kill_wb, kill_mem;
  logic          fence_retires;

  fence_stage_pipe #(.AW(AW)) u_pipe (
    .clk        (clk),
    .rst        (rst),
    .id_fence   (id_fence),
    .id_has_addr(id_has_addr),
    .id_pc      (id_pc),
    .id_operand (id_operand),
    .done       (done),
    .kill_wb    (kill_wb),
    .kill_mem   (kill_mem),
    .mem_ctl    (mem_ctl),
    .mem_pc     (mem_pc),
    .mem_op     (mem_op),
    .wb_ctl     (wb_ctl),
    .wb_pc      (wb_pc)
  );

  fence_redirect_sel #(.AW(AW), .HALFWORD_OK(HALFWORD_OK)) u_sel (
    .mem_ctl            (mem_ctl),
    .mem_pc             (mem_pc),
    .mem_op             (mem_op),
    .wb_ctl             (wb_ctl),
    .wb_pc              (wb_pc),
    .wb_xcpt            (wb_xcpt),
    .mem_jump           (mem_jump),
    .mem_jump_addr      (mem_jump_addr),
    .redirect_valid     (redirect_valid),
    .redirect_target    (redirect_target),
    .redirect_misaligned(redirect_misaligned),
    .replay             (replay),
    .strobe             (itlb_fence),
    .strobe_by_addr     (itlb_fence_by_addr),
    .kill_wb            (kill_wb),
    .kill_mem           (kill_mem)
  );

  assign fence_retires = wb_ctl.valid && !wb_ctl.memop && !wb_xcpt;

  fence_done_flag u_done (
    .clk  (clk),
    .rst  (rst),
    .set  (itlb_fence),
    .clear(wb_retire || wb_xcpt || fence_retires),
    .done (done)
  );
endmodule

// File: rtl/fetch_fence_seq_chk.sv
module fetch_fence_seq_chk (
  input logic clk,
  input logic rst,
  input logic redirect_valid,
  input logic target_lsb,
  input logic redirect_misaligned,
  input logic replay,
  input logic itlb_fence,
  input logic wb_xcpt
);
  AST_STROBE_FOLLOWS_REPLAY: assert property (@(posedge clk) disable iff (rst)
    itlb_fence |-> $past(replay)); // R5
  AST_STROBE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    itlb_fence |=> !itlb_fence); // R5
  AST_STROBE_REFETCH: assert property (@(posedge clk) disable iff (rst)
    itlb_fence |-> redirect_valid && !redirect_misaligned); // R5
  AST_REPLAY_NOT_MISALIGNED: assert property (@(posedge clk) disable iff (rst)
    replay |-> !redirect_misaligned); // R3
  AST_REPLAY_THEN_STROBE: assert property (@(posedge clk) disable iff (rst)
    replay |=> itlb_fence || wb_xcpt); // R8
  AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> !target_lsb); // R2
  AST_XCPT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    wb_xcpt |-> !itlb_fence && !replay); // R8
endmodule

bind fetch_fence_seq fetch_fence_seq_chk u_chk (
  .clk                (clk),
  .rst                (rst),
  .redirect_valid     (redirect_valid),
  .target_lsb         (redirect_target[0]),
  .redirect_misaligned(redirect_misaligned),
  .replay             (replay),
  .itlb_fence         (itlb_fence),
  .wb_xcpt            (wb_xcpt)
);

// File: tb/tb_fetch_fence_seq.sv
module tb_fetch_fence_seq;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          id_fence, id_has_addr, mem_jump, wb_retire, wb_xcpt;
  logic [AW-1:0] id_pc, id_operand, mem_jump_addr;
  logic          redirect_valid, redirect_misaligned, replay, itlb_fence, itlb_fence_by_addr;
  logic [AW-1:0] redirect_target;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fetch_fence_seq #(.AW(AW), .HALFWORD_OK(1'b0)) dut (
    .clk(clk), .rst(rst),
    .id_fence(id_fence), .id_has_addr(id_has_addr), .id_pc(id_pc), .id_operand(id_operand),
    .mem_jump(mem_jump), .mem_jump_addr(mem_jump_addr),
    .wb_retire(wb_retire), .wb_xcpt(wb_xcpt),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target),
    .redirect_misaligned(redirect_misaligned), .replay(replay),
    .itlb_fence(itlb_fence), .itlb_fence_by_addr(itlb_fence_by_addr)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Full sequence with done flag clear: replay/redirect in mem, strobe in wb.
  task automatic full_fence(input logic [AW-1:0] pc, input logic [AW-1:0] op, input logic has);
    id_fence = 1; id_pc = pc; id_operand = op; id_has_addr = has;
    @(negedge clk); id_fence = 0;
    @(negedge clk);
    chk("R2/R4 replay", replay, 1);
    chk("R2/R4 redirect_valid", redirect_valid, has);
    if (has) chk("R2 target", redirect_target, op & ~32'd1);
    chk("R3 fence not misaligned", redirect_misaligned, 0);
    @(negedge clk);
    chk("R5 strobe", itlb_fence, 1);
    chk("R5 by_addr", itlb_fence_by_addr, has);
    chk("R5 refetch valid", redirect_valid, 1);
    chk("R5 refetch target", redirect_target, pc);
    @(negedge clk);
    chk("R5 single pulse", itlb_fence, 0);
    chk("R5 quiet", redirect_valid, 0);
  endtask

  // Fence decoded while done is set.
  task automatic done_pass(input logic [AW-1:0] pc, input logic [AW-1:0] op, input logic has);
    id_fence = 1; id_pc = pc; id_operand = op; id_has_addr = has;
    @(negedge clk); id_fence = 0;
    @(negedge clk);
    chk("R6 no replay", replay, 0);
    chk("R6 redirect_valid", redirect_valid, 1);
    chk("R6 next pc", redirect_target, pc + 32'd4);
    @(negedge clk);
    chk("R6 no strobe", itlb_fence, 0);
    @(negedge clk);
  endtask

  initial begin
    rst = 1; id_fence = 0; id_has_addr = 0; id_pc = 0; id_operand = 0;
    mem_jump = 0; mem_jump_addr = 0; wb_retire = 0; wb_xcpt = 0;
    repeat (3) @(negedge clk);
    chk("R1 redirect in reset", redirect_valid, 0);
    chk("R1 replay in reset", replay, 0);
    chk("R1 strobe in reset", itlb_fence, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 redirect after reset", redirect_valid, 0);
    chk("R1 misaligned after reset", redirect_misaligned, 0);

    // Sweep: with and without operand, several PCs/operands; done-flag round trip.
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < 8; k++) begin
        logic [AW-1:0] pc, op;
        pc = 32'h0000_1000 + 32'(k) * 32'h44;
        op = h[0] ? (32'hA5A5_0000 ^ (32'(k) * 32'd37)) : 32'd0;
        full_fence(pc, op, h[0]);
        done_pass(pc, op, h[0]);
      end
    end

    // R6: done persists across idle cycles until something clears it.
    full_fence(32'h3000, 32'h7777, 1);
    repeat (4) @(negedge clk);
    done_pass(32'h3000, 32'h7777, 1);

    // R7: exception clears done.
    full_fence(32'h3100, 32'h1235, 1);
    wb_xcpt = 1; @(negedge clk); wb_xcpt = 0; @(negedge clk);
    full_fence(32'h3100, 32'h1235, 1);   // R7 full sequence again
    done_pass(32'h3100, 32'h1235, 1);

    // R7: other retirement clears done.
    full_fence(32'h3200, 32'h0, 0);
    wb_retire = 1; @(negedge clk); wb_retire = 0; @(negedge clk);
    full_fence(32'h3200, 32'h0, 0);      // R7 full sequence again
    done_pass(32'h3200, 32'h0, 0);

    // R8: exception while fence in mem.
    id_fence = 1; id_pc = 32'h3300; id_operand = 32'h4444; id_has_addr = 1;
    @(negedge clk); id_fence = 0;
    @(negedge clk); wb_xcpt = 1; #1;
    chk("R8 mem replay squashed", replay, 0);
    chk("R8 mem redirect squashed", redirect_valid, 0);
    @(negedge clk); wb_xcpt = 0; #1;
    chk("R8 no strobe after squash", itlb_fence, 0);
    @(negedge clk);
    full_fence(32'h3300, 32'h4444, 1);   // R8 done was not set

    // R8: exception while fence in wb.
    done_pass(32'h3300, 32'h4444, 1);
    id_fence = 1; id_pc = 32'h3400; id_operand = 32'h5555; id_has_addr = 1;
    @(negedge clk); id_fence = 0;
    @(negedge clk);
    @(negedge clk); wb_xcpt = 1; #1;
    chk("R8 wb strobe squashed", itlb_fence, 0);
    chk("R8 wb redirect squashed", redirect_valid, 0);
    @(negedge clk); wb_xcpt = 0;
    @(negedge clk);
    full_fence(32'h3400, 32'h5555, 1);   // R8 done was not set
    done_pass(32'h3400, 32'h5555, 1);

    // R9 / R3: indirect jump sweep over low address bits.
    for (int a = 0; a < 16; a++) begin
      logic [AW-1:0] ja;
      ja = 32'h0000_2000 + 32'(a) * 32'h101;
      mem_jump = 1; mem_jump_addr = ja; #1;
      chk("R9 jump valid", redirect_valid, 1);
      chk("R9 jump target", redirect_target, ja & ~32'd1);
      chk("R9 jump no replay", replay, 0);
      chk("R3 jump misaligned", redirect_misaligned, 32'(ja[1]));
      @(negedge clk); mem_jump = 0;
      @(negedge clk);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule